// File: doc/BRIEF.md
# Gated-Period Tone Frequency Counter

This block measures the frequency of a received tone that has already been filtered and squared into a single digital signal. Each measurement runs over a fixed window of 511 periods of a measuring clock. That clock reaches the block as a one-cycle enable, `ref_tick`, at 56 kHz for the high and extended bands and at 28 kHz for the mid band. Within the window the block counts the tone events, which gives the integer part. It also counts the measuring-clock periods that pass after the last counted event up to the end of the window, which gives the remainder.

In the high and mid bands both tone edges are counted, so the integer counts cycles at twice the tone frequency. In the extended band only rising edges are counted. Software recovers the tone frequency as K·N/(511−R), with K equal to 28000 for high, 14000 for mid and 56000 for extended. Windows follow one another back to back for as long as `run` is held high. A window that saw no counted event is discarded. A progress flag shows that three quarters of the window have elapsed, so a supervising timer can tell whether a measurement is nearly complete.

Top module: `tone_freq_counter`

## Requirements
- R1: While `run` is high, a window ends on the 511th `ref_tick` after it started. The next window begins counting on the following tick with no gap.
- R2: With `band` = 2'b00 (high) or 2'b01 (mid), every rising and every falling edge of the synchronized tone counts as one event.
- R3: With `band` = 2'b10 (extended), only rising edges of the synchronized tone count as events. Falling edges are ignored.
- R4: The remainder R is the number of `ref_tick` pulses that occur after the last counted event in the window, up to and including the tick that closes the window.
- R5: `result` holds N in bits 15:9 and R in bits 8:0. The upper byte is therefore the one that carries the count, and it is sent first.
- R6: `done` is high for exactly one cycle, in the cycle after the closing tick, and `result` takes the new value in that same cycle.
- R7: A window with zero counted events raises no `done`, and `result` keeps its previous value.
- R8: `progress` is high from the 384th tick of a window until the window closes, and low at all other times.
- R9: With `run` low, no window runs: `done` and `progress` stay low, and tone edges have no effect. A new window starts from zero after `run` returns high.
- R10: N saturates at 127 and does not wrap.
- R11: After reset, `result` is 0 and both `done` and `progress` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High: measure continuously. Low: abort and hold idle |
| band | input | 2 | 00 high, 01 mid, 10 extended, 11 treated as high |
| ref_tick | input | 1 | One-cycle enable marking each measuring-clock period |
| tone_in | input | 1 | Squared tone, asynchronous |
| result | output | 16 | {N[6:0], R[8:0]} of the last valid window |
| done | output | 1 | One-cycle pulse when a valid result is stored |
| progress | output | 1 | High once 384 ticks of the current window have elapsed |

## Verification
The bench places tone edges at known tick positions and aims at the window boundary. An event just before the closing tick must give R = 1. A design that dropped that event, or that counted ticks from the start of the window, would report a different N or R. Extended-band windows use the same edge pattern as high-band windows, so a design that counted both edges there would report roughly double the count. An empty window, an aborted window and a window with an edge on every tick check that the design discards results without a pulse and saturates N instead of wrapping. The progress flag is sampled at ticks 383, 384, 510 and 511 to catch off-by-one thresholds.

// File: rtl/tfc_pkg.sv
`timescale 1ns/1ps
// Package: shared band encoding and edge-mode decode for the tone counter.
// Assumes band codes are stable during a window; 2'b11 is treated like high.
package tfc_pkg;
    typedef enum logic [1:0] {
        BAND_HIGH = 2'b00,
        BAND_MID  = 2'b01,
        BAND_EXT  = 2'b10,
        BAND_RSV  = 2'b11
    } band_e;

    // True when both tone edges are counted for the given band.
    function automatic logic count_both_edges(input logic [1:0] b);
        return (b != BAND_EXT);
    endfunction
endpackage

// File: rtl/tfc_edge_detect.sv
`timescale 1ns/1ps
// Module: synchronizes the squared tone and flags counted edges.
// Assumes tone_in is asynchronous; SYNC_STAGES >= 2. An event is a change of the
// synchronized level (both-edge mode) or a rise only (rising-edge mode).
module tfc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    input  logic both_edges,
    output logic evt
);
    logic [SYNC_STAGES:0] shreg;
    logic cur_lvl;
    logic prev_lvl;

    // Shift chain: synchronizer stages plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], tone_in};
    end

    assign cur_lvl  = shreg[SYNC_STAGES-1];
    assign prev_lvl = shreg[SYNC_STAGES];

    // Event select by edge mode.
    always_comb begin
        if (both_edges) evt = cur_lvl ^ prev_lvl;
        else            evt = cur_lvl & ~prev_lvl;
    end

    // R3
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !both_edges) |=> shreg[SYNC_STAGES]);
endmodule

// File: rtl/tfc_window_timer.sv
`timescale 1ns/1ps
// Module: counts measuring-clock ticks to frame each window and flags progress.
// Assumes ref_tick is a one-cycle enable; counter is cleared while inactive.
module tfc_window_timer #(
    parameter int WIN_TICKS  = 511,
    parameter int PROG_TICKS = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_tick,
    output logic win_end,
    output logic progress
);
    localparam int CNT_W = $clog2(WIN_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_TICKS - 1);
    localparam logic [CNT_W-1:0] PROG_IDX = CNT_W'(PROG_TICKS);

    logic [CNT_W-1:0] cnt;

    assign win_end  = active && ref_tick && (cnt == LAST_IDX);
    assign progress = active && (cnt >= PROG_IDX);

    // Tick counter: wraps at the window end, held at zero when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (ref_tick)     cnt <= win_end ? '0 : cnt + 1'b1;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);
    // R1
    win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (cnt == '0));
    // R8
    prog_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ref_tick && cnt == PROG_IDX - 1'b1) |=> (progress || !active));
endmodule

// File: rtl/tfc_event_counter.sv
`timescale 1ns/1ps
// Module: accumulates the event count N and the ticks since the last event R.
// Assumes evt and tick are single-cycle; both saturate instead of wrapping.
module tfc_event_counter #(
    parameter int N_W = 7,
    parameter int R_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           evt,
    input  logic           tick,
    input  logic           win_end,
    output logic [N_W-1:0] n_nxt,
    output logic [R_W-1:0] r_nxt
);
    localparam logic [N_W-1:0] N_MAX = '1;
    localparam logic [R_W-1:0] R_MAX = '1;

    logic [N_W-1:0] n_cnt;
    logic [R_W-1:0] r_cnt;

    // Next values including this cycle's event and tick.
    always_comb begin
        n_nxt = (evt && n_cnt != N_MAX) ? n_cnt + 1'b1 : n_cnt;
        if (evt)                            r_nxt = '0;
        else if (tick && r_cnt != R_MAX)    r_nxt = r_cnt + 1'b1;
        else                                r_nxt = r_cnt;
    end

    // Running registers: restart at each window boundary or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || win_end) begin
            n_cnt <= '0;
            r_cnt <= '0;
        end else begin
            n_cnt <= n_nxt;
            r_cnt <= r_nxt;
        end
    end

    // R10
    n_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_cnt == N_MAX && !clear && !win_end) |=> (n_cnt == N_MAX));
    // R4
    r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clear && !win_end) |=> (r_cnt == '0));
endmodule

// File: rtl/tone_freq_counter.sv
`timescale 1ns/1ps
// Module: top of the gated-period tone frequency counter.
// Assumes ref_tick runs at the band's measuring rate; run low aborts and idles.
// Stores {N, R} and pulses done when a window with at least one event closes.
module tone_freq_counter #(
    parameter int WIN_TICKS   = 511,
    parameter int PROG_TICKS  = 384,
    parameter int N_W         = 7,
    parameter int R_W         = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [1:0]           band,
    input  logic                 ref_tick,
    input  logic                 tone_in,
    output logic [N_W+R_W-1:0]   result,
    output logic                 done,
    output logic                 progress
);
    import tfc_pkg::*;

    logic           active;
    logic           evt;
    logic           win_end;
    logic [N_W-1:0] n_nxt;
    logic [R_W-1:0] r_nxt;

    // Run qualifier: a window starts one cycle after run is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= run;
    end

    tfc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_in    (tone_in),
        .both_edges (count_both_edges(band)),
        .evt        (evt)
    );

    tfc_window_timer #(.WIN_TICKS(WIN_TICKS), .PROG_TICKS(PROG_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ref_tick (ref_tick),
        .win_end  (win_end),
        .progress (progress)
    );

    tfc_event_counter #(.N_W(N_W), .R_W(R_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!active),
        .evt     (evt && active),
        .tick    (ref_tick && active),
        .win_end (win_end),
        .n_nxt   (n_nxt),
        .r_nxt   (r_nxt)
    );

    // Result capture and completion pulse; empty windows are discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= win_end && (n_nxt != '0);
            if (win_end && n_nxt != '0) result <= {n_nxt, r_nxt};
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[N_W+R_W-1:R_W] != '0));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!done && !progress));
endmodule

// File: tb/tb_tone_freq_counter.sv
`timescale 1ns/1ps
// Directed bench: tone edges placed on known tick groups; one task per scenario.
module tb_tone_freq_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  band = 2'b00;
    logic        ref_tick = 1'b0;
    logic        tone_in = 1'b0;
    logic [15:0] result;
    logic        done;
    logic        progress;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_result = 16'h0;

    always #4 clk = ~clk;

    tone_freq_counter dut (
        .clk(clk), .rst_n(rst_n), .run(run), .band(band),
        .ref_tick(ref_tick), .tone_in(tone_in),
        .result(result), .done(done), .progress(progress)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One tick group: optional tone toggle, three quiet cycles, then a tick.
    task automatic group(input bit toggle);
        ref_tick = 1'b0;
        if (toggle) tone_in = ~tone_in;
        repeat (3) @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
    endtask

    // Full window; toggles at first, first+period, ... ; checks result.
    task automatic run_window(input logic [1:0] b, input int first, input int period,
                              input string req);
        int n_exp = 0;
        int last = 0;
        bit both = (b != 2'b10);
        band = b;
        for (int k = 1; k <= 511; k++) begin
            bit t = (period > 0) && (k >= first) && ((k - first) % period == 0);
            if (t && (both || tone_in == 1'b0)) begin
                n_exp++;
                last = k;
            end
            group(t);
            if (k == 383) chk(progress == 1'b0, "R8", "progress@383", progress, 0);
            if (k == 384) chk(progress == 1'b1, "R8", "progress@384", progress, 1);
            if (k == 510) chk(progress == 1'b1, "R8", "progress@510", progress, 1);
            if (k < 511 && done) chk(1'b0, "R1", "early done", k, 511);
        end
        ref_tick = 1'b0;
        chk(progress == 1'b0, "R8", "progress after close", progress, 0);
        if (n_exp > 127) n_exp = 127;
        if (n_exp == 0) begin
            chk(done == 1'b0, "R7", "done on empty window", done, 0);
            chk(result == last_result, "R7", "result held", result, last_result);
        end else begin
            logic [15:0] exp_word = {7'(n_exp), 9'(512 - last)};
            chk(done == 1'b1, "R6", "done after closing tick", done, 1);
            chk(result[15:9] == 7'(n_exp), req, "N field", result[15:9], n_exp);
            chk(result[8:0] == 9'(512 - last), "R4", "R field", result[8:0], 512 - last);
            chk(result == exp_word, "R5", "word layout", result, exp_word);
            last_result = exp_word;
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", done, 0);
    endtask

    task automatic test_reset();
        chk(result == 16'h0, "R11", "reset result", result, 0);
        chk(done == 1'b0, "R11", "reset done", done, 0);
        chk(progress == 1'b0, "R11", "reset progress", progress, 0);
    endtask

    // R9: abort mid-window, toggle while idle, restart fresh.
    task automatic test_abort();
        band = 2'b00;
        for (int k = 1; k <= 450; k++) group(k % 4 == 0);
        run = 1'b0;
        ref_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(progress == 1'b0, "R9", "progress after abort", progress, 0);
        for (int k = 1; k <= 80; k++) begin
            group(1'b1);
            if (done) chk(1'b0, "R9", "done while idle", done, 0);
        end
        ref_tick = 1'b0;
        chk(done == 1'b0 && result == last_result, "R9", "idle result held",
            result, last_result);
        tone_in = 1'b0;
        repeat (4) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        run_window(2'b00, 3, 9, "R9");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run = 1'b1;
        @(negedge clk);
        run_window(2'b00, 5, 10, "R2");   // high: 51 edges, R=7
        run_window(2'b10, 5, 10, "R3");   // extended: rising only
        run_window(2'b01, 2, 7, "R2");    // mid: both edges
        run_window(2'b00, 0, 0, "R7");    // empty window
        run_window(2'b00, 1, 1, "R10");   // edge every group, saturate, R=1
        test_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule